// File: doc/BRIEF.md
# Protected Reset Command Sequencer

This block watches the register write strobe of a small recording device for a protected reset command. The command is the byte 55h written twice to register address 1Dh. It counts only while the device's reset-enable bit is set. Unrelated writes may fall between the two command writes. A power-on reset, or a write of any other value to 1Dh, drops a half-finished command.

When the second command write arrives, the block does five things in the next cycle. It pulses a clear to the elapsed-time counter and to the event counter. It pulses a clear of the configuration flags: the alarm flag, the reset-enable bit and the event-count high bit. It pulses a storage commit request. It raises a lock that makes the configuration register read-only. The lock holds until the next power-on reset, and no further command is honoured while it holds. Decoding the bus protocol is left to the logic upstream.

Top module: `rstcmd_seq`

## Requirements
- R1: After a power-on reset (`por_n` low), every pulse output and `cfg_lock` are 0.
- R2: Two writes of 55h to address 1Dh, each with `rst_enable` = 1, fire the command. `clr_elapsed`, `clr_events`, `clr_cfg_flags` and `commit_req` go high in the cycle after the clock edge that samples the second write.
- R3: Writes to addresses other than 1Dh, and idle cycles, between the two command writes do not disturb the sequence.
- R4: A write to 1Dh with a value other than 55h returns the sequencer to idle. Two fresh 55h writes are then needed.
- R5: A 55h write to 1Dh while `rst_enable` = 0 has no effect: it neither arms nor completes the sequence.
- R6: A power-on reset between the first and second command writes abandons the sequence.
- R7: The four pulse outputs are high together for exactly one cycle.
- R8: `cfg_lock` rises in the same cycle as the pulses and stays high until the next power-on reset.
- R9: Once the command has fired, further command writes produce no pulses until the next power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rst_enable | input | 1 | Reset-enable bit from the configuration register |
| clr_elapsed | output | 1 | One-cycle clear of the elapsed-time counter |
| clr_events | output | 1 | One-cycle clear of the event counter |
| clr_cfg_flags | output | 1 | One-cycle clear of the alarm flag, reset-enable bit and event-count high bit |
| commit_req | output | 1 | One-cycle request to commit registers to storage |
| cfg_lock | output | 1 | Configuration register read-only, sticky until power-on reset |

## Verification
The bench places unrelated writes between the two command writes. A design that required back-to-back writes would miss the command. It writes other values to 1Dh while the sequence is half done. A design that ignored them would fire on a stale first write. It toggles `rst_enable` and applies power-on resets mid-sequence. A design that armed while disabled, or kept its armed state across a power-on reset, would fire early. After completion it keeps sending the command. A design that failed to latch completion would pulse the clears a second time or drop the lock.

// File: rtl/rstcmd_seq.sv
module rstcmd_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h1D,
  parameter logic [DATA_W-1:0] CMD_DATA = 8'h55
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rst_enable,
  output logic              clr_elapsed,
  output logic              clr_events,
  output logic              clr_cfg_flags,
  output logic              commit_req,
  output logic              cfg_lock
);

  logic armed, done, fire;

  wire hit_addr = wr_en && (wr_addr == CMD_ADDR);
  wire cmd_ok   = hit_addr && (wr_data == CMD_DATA) && rst_enable && !done;
  wire bad_val  = hit_addr && (wr_data != CMD_DATA);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed <= 1'b0;
      done  <= 1'b0;
      fire  <= 1'b0;
    end else begin
      fire <= armed && cmd_ok;
      if (armed && cmd_ok) begin
        done  <= 1'b1;
        armed <= 1'b0;
      end else if (bad_val || done) begin
        armed <= 1'b0;
      end else if (cmd_ok) begin
        armed <= 1'b1;
      end
    end
  end

  assign clr_elapsed   = fire;
  assign clr_events    = fire;
  assign clr_cfg_flags = fire;
  assign commit_req    = fire;
  assign cfg_lock      = done;

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!por_n)
    commit_req |=> !commit_req);
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    cfg_lock |=> cfg_lock);
  p_lock_with_pulse_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cfg_lock) |-> (clr_elapsed && commit_req));
  p_no_refire_r9: assert property (@(posedge clk) disable iff (!por_n)
    cfg_lock |=> !clr_elapsed);
  p_needs_enable_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(clr_events) |-> $past(rst_enable && wr_en));

endmodule

// File: tb/sim_rstcmd_seq.sv
module sim_rstcmd_seq;
  logic clk = 0, por_n = 0, wr_en = 0, rst_enable = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic clr_elapsed, clr_events, clr_cfg_flags, commit_req, cfg_lock;
  int n_chk = 0, n_fail = 0;
  bit m_armed = 0, m_done = 0, m_fire = 0;

  always #2 clk = ~clk;

  rstcmd_seq u0 (.clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_enable(rst_enable), .clr_elapsed(clr_elapsed),
    .clr_events(clr_events), .clr_cfg_flags(clr_cfg_flags),
    .commit_req(commit_req), .cfg_lock(cfg_lock));

  function automatic logic [4:0] exp_vec(bit f, bit l);
    return {f, f, f, f, l};
  endfunction

  task automatic check(string tag);
    logic [4:0] act = {clr_elapsed, clr_events, clr_cfg_flags, commit_req, cfg_lock};
    logic [4:0] exp = exp_vec(m_fire, m_done);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(bit we, logic [7:0] a, logic [7:0] d, bit en, string tag);
    bit hit = we && a == 8'h1D;
    bit ok  = hit && d == 8'h55 && en && !m_done;
    wr_en = we; wr_addr = a; wr_data = d; rst_enable = en;
    m_fire = m_armed && ok;
    if (m_fire) begin m_done = 1; m_armed = 0; end
    else if ((hit && d != 8'h55) || m_done) m_armed = 0;
    else if (ok) m_armed = 1;
    @(negedge clk);
    wr_en = 0;
    check(tag);
  endtask

  task automatic por(string tag);
    por_n = 0; wr_en = 0;
    m_armed = 0; m_done = 0; m_fire = 0;
    repeat (2) @(negedge clk);
    check(tag);
    por_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    por("R1");
    step(1, 8'h1D, 8'h55, 1, "R2");
    step(1, 8'h1D, 8'h55, 1, "R2");
    step(0, 8'h00, 8'h00, 1, "R7");
    step(1, 8'h1D, 8'h55, 1, "R9");
    step(1, 8'h1D, 8'h55, 1, "R9");
    step(0, 8'h00, 8'h00, 0, "R8");
    por("R8");
    step(1, 8'h1D, 8'h55, 1, "R3");
    step(1, 8'h10, 8'h55, 1, "R3");
    step(0, 8'h00, 8'h00, 1, "R3");
    step(1, 8'h1D, 8'h55, 1, "R3");
    por("R1");
    step(1, 8'h1D, 8'h55, 1, "R4");
    step(1, 8'h1D, 8'h54, 1, "R4");
    step(1, 8'h1D, 8'h55, 1, "R4");
    step(1, 8'h1D, 8'h55, 1, "R4");
    por("R1");
    step(1, 8'h1D, 8'h55, 0, "R5");
    step(1, 8'h1D, 8'h55, 1, "R5");
    step(1, 8'h1D, 8'h55, 0, "R5");
    step(1, 8'h1D, 8'h55, 1, "R5");
    por("R1");
    step(1, 8'h1D, 8'h55, 1, "R6");
    por("R6");
    step(1, 8'h1D, 8'h55, 1, "R6");
    step(1, 8'h1D, 8'h55, 1, "R6");
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 299) == 0) por("R6");
      else step($urandom_range(0, 3) != 0,
                ($urandom_range(0, 2) != 0) ? 8'h1D : 8'($urandom),
                ($urandom_range(0, 3) != 0) ? 8'h55 : 8'($urandom),
                $urandom_range(0, 4) != 0, "R7");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule